// File: doc/BRIEF.md
# Packed DMA Interrupt Flag Bank

This block keeps the event flags of an eight-stream DMA controller. Each stream engine sends one-cycle pulses for five kinds of event: done, half-done, transfer error, direct-mode error and FIFO error. The block latches each pulse into a sticky flag. Software sees all eight streams' flags through two 32-bit status words on a single-cycle register port. It removes flags by writing ones to two matching clear words.

Each stream's five flags form one six-bit group. Four groups share each status word, at bases 0, 6, 16 and 22. The block also gives one level interrupt per stream. That line is the OR of the stream's flags, each masked by its own enable input.

The asynchronous active-low reset is synchronised internally before it is released.

Top module: `dma_flag_bank`

## Requirements
- R1: Within a stream's six-bit group, the flags sit at these offsets from the group base: FIFO error (`evt_fifo`) at 0, direct-mode error (`evt_dmode`) at 2, transfer error (`evt_xerr`) at 3, half-done (`evt_half`) at 4, done (`evt_done`) at 5. Offset 1, and every word bit outside the groups, reads as zero.
- R2: Streams 0 to 3 appear in the low status word and streams 4 to 7 in the high status word. The group base is 16 when stream index bit 1 is set, plus 6 when stream index bit 0 is set, giving bases 0, 6, 16 and 22.
- R3: The word addresses are fixed. Address 0x0 is the low status word, 0x4 the high status word, 0x8 the low clear word and 0xC the high clear word. Read data appears in the same cycle as the address. An address whose two low bits are not zero matches no register: reads return zero and writes have no effect.
- R4: An event pulse sampled at a clock edge sets its flag, and the new value is visible after that edge. A flag keeps its value until it is cleared, and it never rises without a pulse.
- R5: Writing a one to a clear-word bit clears the flag at the same position in the matching status word, as of the next edge. Zero bits in the written word have no effect, and a clear write does not touch the other status word.
- R6: When a set pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R7: Writes to the status word addresses change no flag.
- R8: Reads of the clear word addresses return zero. When `bus_sel` is low or `bus_wr` is high, `bus_rdata` is zero.
- R9: `irq[s]` is high whenever stream s has at least one set flag whose own enable input (`ie_done`, `ie_half`, `ie_xerr`, `ie_dmode`, `ie_fifo`) is high. It stays high until every such flag is cleared, and it follows changes of the enables in the same cycle.
- R10: While reset is held, and after it is released, all flags and all `irq` lines are zero until an event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| evt_done | input | 8 | Per-stream done event pulses |
| evt_half | input | 8 | Per-stream half-done event pulses |
| evt_xerr | input | 8 | Per-stream transfer-error event pulses |
| evt_dmode | input | 8 | Per-stream direct-mode-error event pulses |
| evt_fifo | input | 8 | Per-stream FIFO-error event pulses |
| ie_done | input | 8 | Per-stream done interrupt enables |
| ie_half | input | 8 | Per-stream half-done interrupt enables |
| ie_xerr | input | 8 | Per-stream transfer-error interrupt enables |
| ie_dmode | input | 8 | Per-stream direct-mode-error interrupt enables |
| ie_fifo | input | 8 | Per-stream FIFO-error interrupt enables |
| irq | output | 8 | Per-stream level interrupt |

## Verification
An event pulse from a stream engine and a software clear write can land on the same flag in the same clock cycle. The bench provokes this for every stream and every flag kind. It pulses one event while writing all ones to that stream's clear word, then reads the status word back and expects the flag still set. A long pseudo-random phase then overlaps pulses, clear writes to all addresses (unaligned ones included) and changing enables. After every cycle it compares both status words and the interrupt vector with an arithmetic model of set-or-hold-and-not-clear.

// File: rtl/dma_flag_pkg.sv
package dma_flag_pkg;
  localparam int NUM_STREAMS      = 8;
  localparam int STREAMS_PER_WORD = 4;
  localparam int NUM_WORDS        = NUM_STREAMS / STREAMS_PER_WORD;
  localparam int WORD_W           = 32;
  localparam int ADDR_W           = 4;
  localparam int WSEL_W           = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int NUM_KINDS        = 5;

  // kind index: 0 fifo, 1 direct-mode, 2 transfer error, 3 half, 4 done
  function automatic int kind_bit(input int k);
    case (k)
      0:       return 0;
      1:       return 2;
      2:       return 3;
      3:       return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int group_base(input int s);
    return (((s >> 1) & 1) * 16) + ((s & 1) * 6);
  endfunction

  function automatic int group_word(input int s);
    return s / STREAMS_PER_WORD;
  endfunction

  function automatic logic [WORD_W-1:0] flag_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int s = 0; s < STREAMS_PER_WORD; s++)
      for (int k = 0; k < NUM_KINDS; k++)
        m[group_base(s) + kind_bit(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dma_flag_decode.sv
module dma_flag_decode
  import dma_flag_pkg::*;
(
  input  logic                                  bus_sel,
  input  logic                                  bus_wr,
  input  logic [ADDR_W-1:0]                     bus_addr,
  input  logic [WORD_W-1:0]                     bus_wdata,
  output logic [NUM_STREAMS-1:0][NUM_KINDS-1:0] clr_o,
  output logic                                  rd_stat_o,
  output logic [WSEL_W-1:0]                     rd_word_o
);
  localparam logic [WORD_W-1:0] FMASK = flag_mask();

  logic              aligned;
  logic              is_clear;
  logic [WSEL_W-1:0] widx;
  logic              wr_clear;
  logic              unused_wdata_bits;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign is_clear = bus_addr[ADDR_W-1];
  assign widx     = bus_addr[2 +: WSEL_W];
  assign wr_clear = bus_sel & bus_wr & aligned & is_clear;

  always_comb begin
    for (int s = 0; s < NUM_STREAMS; s++)
      for (int k = 0; k < NUM_KINDS; k++)
        clr_o[s][k] = wr_clear && (widx == WSEL_W'(group_word(s)))
                      && bus_wdata[group_base(s) + kind_bit(k)];
  end

  assign rd_stat_o = bus_sel & ~bus_wr & aligned & ~is_clear;
  assign rd_word_o = widx;

  assign unused_wdata_bits = ^(bus_wdata & ~FMASK);
endmodule

// File: rtl/dma_flag_group.sv
module dma_flag_group #(
  parameter int KINDS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KINDS-1:0] set_i,
  input  logic [KINDS-1:0] clr_i,
  input  logic [KINDS-1:0] en_i,
  output logic [KINDS-1:0] flags_o,
  output logic             irq_o
);
  logic [KINDS-1:0] flags_q;
  logic [KINDS-1:0] flags_d;
  logic             upd;

  // set has priority over a same-cycle clear
  always_comb begin
    upd     = (|set_i) | (|clr_i);
    flags_d = set_i | (flags_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags_q <= '0;
    else if (upd) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & clr_i)) |=> ((flags_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));

  assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank
  import dma_flag_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [WORD_W-1:0]      bus_wdata,
  output logic [WORD_W-1:0]      bus_rdata,
  input  logic [NUM_STREAMS-1:0] evt_done,
  input  logic [NUM_STREAMS-1:0] evt_half,
  input  logic [NUM_STREAMS-1:0] evt_xerr,
  input  logic [NUM_STREAMS-1:0] evt_dmode,
  input  logic [NUM_STREAMS-1:0] evt_fifo,
  input  logic [NUM_STREAMS-1:0] ie_done,
  input  logic [NUM_STREAMS-1:0] ie_half,
  input  logic [NUM_STREAMS-1:0] ie_xerr,
  input  logic [NUM_STREAMS-1:0] ie_dmode,
  input  logic [NUM_STREAMS-1:0] ie_fifo,
  output logic [NUM_STREAMS-1:0] irq
);
  localparam logic [WORD_W-1:0] FMASK = flag_mask();

  logic [1:0]                            rst_sync_q;
  logic                                  rst_int_n;
  logic [NUM_STREAMS-1:0][NUM_KINDS-1:0] clr_v;
  logic [NUM_STREAMS-1:0][NUM_KINDS-1:0] flags_v;
  logic [NUM_WORDS-1:0][WORD_W-1:0]      stat_w;
  logic                                  rd_stat;
  logic [WSEL_W-1:0]                     rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dma_flag_decode u_decode (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .clr_o     (clr_v),
    .rd_stat_o (rd_stat),
    .rd_word_o (rd_word)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    dma_flag_group #(.KINDS(NUM_KINDS)) u_group (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .set_i   ({evt_done[s], evt_half[s], evt_xerr[s], evt_dmode[s], evt_fifo[s]}),
      .clr_i   (clr_v[s]),
      .en_i    ({ie_done[s], ie_half[s], ie_xerr[s], ie_dmode[s], ie_fifo[s]}),
      .flags_o (flags_v[s]),
      .irq_o   (irq[s])
    );
  end

  always_comb begin
    stat_w = '0;
    for (int s = 0; s < NUM_STREAMS; s++)
      for (int k = 0; k < NUM_KINDS; k++)
        stat_w[group_word(s)][(group_base(s % STREAMS_PER_WORD)) + kind_bit(k)] = flags_v[s][k];
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_stat) bus_rdata = stat_w[rd_word];
  end

  assert_clear_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_sel && !bus_wr && bus_addr[ADDR_W-1]) |-> (bus_rdata == '0));

  assert_spare_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |-> ((bus_rdata & ~FMASK) == '0));
endmodule

// File: tb/dma_flag_bank_bench.sv
module dma_flag_bank_bench;
  localparam int PERIOD = 20;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [4:0][NS-1:0] ev_b, ie_b;
  logic [NS-1:0] irq;
  logic [31:0] mdl [2];
  int nvec = 0;
  int nerr = 0;

  always #(PERIOD/2) clk = ~clk;

  dma_flag_bank u_dma_flag_bank (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_done(ev_b[4]), .evt_half(ev_b[3]), .evt_xerr(ev_b[2]),
    .evt_dmode(ev_b[1]), .evt_fifo(ev_b[0]),
    .ie_done(ie_b[4]), .ie_half(ie_b[3]), .ie_xerr(ie_b[2]),
    .ie_dmode(ie_b[1]), .ie_fifo(ie_b[0]),
    .irq(irq)
  );

  // R1/R2 placement, computed from the stated offsets and bases
  function automatic int pos(input int s, input int k);
    int off;
    off = (k == 0) ? 0 : (k + 1);
    return (((s >> 1) & 1) * 16) + ((s & 1) * 6) + off;
  endfunction

  function automatic logic [NS-1:0] exp_irq();
    logic [NS-1:0] e;
    e = '0;
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 5; k++)
        if (mdl[s/4][pos(s, k)] && ie_b[k][s]) e[s] = 1'b1;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock cycle of stimulus; starts and ends just after a falling edge
  task automatic tick(input logic [4:0][NS-1:0] sets, input logic wr,
                      input logic [3:0] addr, input logic [31:0] wd);
    logic [31:0] img [2];
    logic [31:0] c0, c1;
    ev_b = sets; bus_sel = wr; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    img[0] = '0; img[1] = '0;
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 5; k++)
        if (sets[k][s]) img[s/4][pos(s, k)] = 1'b1;
    c0 = (wr && addr == 4'h8) ? wd : '0;
    c1 = (wr && addr == 4'hC) ? wd : '0;
    @(posedge clk);
    mdl[0] = img[0] | (mdl[0] & ~c0);
    mdl[1] = img[1] | (mdl[1] & ~c1);
    @(negedge clk);
    ev_b = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic check_all(input string tag);
    logic [3:0] addrs [5];
    logic [31:0] exp;
    addrs = '{4'h0, 4'h4, 4'h8, 4'hC, 4'h1};
    for (int i = 0; i < 5; i++) begin
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addrs[i];
      #1;
      exp = (addrs[i] == 4'h0) ? mdl[0] : (addrs[i] == 4'h4) ? mdl[1] : 32'h0;
      chk(bus_rdata == exp, tag, bus_rdata, exp);
    end
    bus_sel = 1'b0;
    #1;
    chk(irq == exp_irq(), {tag, " R9 irq"}, {24'h0, irq}, {24'h0, exp_irq()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [4:0][NS-1:0] one;
    logic [31:0] km [2];
    logic [63:0] ra, rb;
    logic [31:0] lf;
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    ev_b = '0; ie_b = '0; mdl[0] = '0; mdl[1] = '0;
    repeat (3) @(negedge clk);
    ie_b = '1;
    #1;
    chk(irq == '0, "R10 irq in reset", {24'h0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R10 after reset");

    // per stream, per kind: set, ignored writes, exact clear
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 5; k++) begin
        one = '0; one[k][s] = 1'b1;
        tick(one, 1'b0, 4'h0, '0);
        check_all("R1/R2/R4 set");
        tick('0, 1'b1, (s < 4) ? 4'h8 : 4'hC, 32'h0);
        check_all("R5 zero write");
        tick('0, 1'b1, (s < 4) ? 4'h0 : 4'h4, 32'hFFFF_FFFF);
        check_all("R7 status write");
        tick('0, 1'b1, (s < 4) ? 4'hC : 4'h8, 32'h1 << pos(s, k));
        check_all("R5 other word");
        tick('0, 1'b1, (s < 4) ? 4'h9 : 4'hD, 32'h1 << pos(s, k));
        check_all("R3 unaligned write");
        tick('0, 1'b1, (s < 4) ? 4'h8 : 4'hC, 32'h1 << pos(s, k));
        check_all("R5 clear");
      end

    // enable gating and level behaviour
    tick('1, 1'b0, 4'h0, '0);
    check_all("R9 all set");
    for (int j = 0; j < 5; j++) begin
      ie_b = '0; ie_b[j] = '1;
      check_all("R9 single enable");
    end
    ie_b = '0;
    check_all("R9 none enabled");
    ie_b = '1;
    for (int k = 0; k < 5; k++) begin
      km[0] = '0; km[1] = '0;
      for (int s = 0; s < NS; s++) km[s/4][pos(s, k)] = 1'b1;
      tick('0, 1'b1, 4'h8, km[0]);
      tick('0, 1'b1, 4'hC, km[1]);
      check_all("R9 level until last clear");
    end

    // set and clear on the same flag in one cycle
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 5; k++) begin
        one = '0; one[k][s] = 1'b1;
        tick(one, 1'b1, (s < 4) ? 4'h8 : 4'hC, 32'hFFFF_FFFF);
        check_all("R6 set wins");
        tick('0, 1'b1, (s < 4) ? 4'h8 : 4'hC, 32'hFFFF_FFFF);
        check_all("R5 clear after collision");
      end

    // pseudo-random overlap of events, writes and enables
    lf = 32'h1D2C_3B4A;
    for (int n = 0; n < 400; n++) begin
      for (int b = 0; b < 4; b++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        case (b)
          0: ra[31:0]  = lf;
          1: ra[63:32] = lf;
          2: rb[31:0]  = lf;
          default: rb[63:32] = lf;
        endcase
      end
      one = '0;
      for (int s = 0; s < NS; s++)
        for (int k = 0; k < 5; k++) begin
          one[k][s] = ra[k*8+s] & rb[k*8+s] & ra[63-(k*8+s)];
          ie_b[k][s] = rb[k*8+s+3];
        end
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      tick(one, ra[45],
           (ra[47:46] == 2'd0) ? 4'h8 : (ra[47:46] == 2'd1) ? 4'hC :
           (ra[48] ? 4'h9 : 4'h4), lf);
      check_all("R3/R4/R5/R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule